// File: doc/BRIEF.md
# Oversampling Serial Receiver with Two-Entry Character Queue

This block receives asynchronous serial characters on a single input line. The line is first passed through a synchronizer. It is then sampled once per pulse of an external oversampling tick. The tick rate is sixteen samples per bit in the normal mode and eight samples per bit when the fast-mode select is high. The select may change between characters. While the receiver waits for a character, it looks for a high-to-low transition of the line. The sample that first sees the line low becomes sample 1 of the start bit, and the timing of every later bit counts from there. Each bit value is the majority vote of three samples around the bit centre, so a single corrupted sample does not alter the result.

Completed characters go into a two-entry queue. A flag shows when a character is waiting. Each read strobe pops the oldest character into the registered output. A character that arrives while the queue is full is lost, and a sticky flag records the loss. Dropping the enable aborts the character in progress, empties the queue and gives up ownership of the pin at once. Software can also drain the queue by reading until the flag clears.

Top module: `uart_rx_os`

## Requirements
- R1: With `fast_mode`=0, each bit lasts 16 ticks. Sample 1 of the start bit is the first tick that sees the line low after a tick that saw it high.
- R2: With `fast_mode`=1, each bit lasts 8 ticks. The start alignment is the same as in R1.
- R3: Each bit takes the majority of samples 8, 9 and 10 (16x mode) or samples 4, 5 and 6 (8x mode). One inverted sample at the bit centre therefore leaves the received value unchanged.
- R4: If the start bit votes high at its centre, the receiver returns to waiting for a start edge and stores nothing.
- R5: A frame is one low start bit, 8 data bits sent LSB first, and one stop bit. The character is stored when the stop bit's vote completes. `rd_ferr` reads 1 if the stop bit voted low and 0 otherwise.
- R6: The queue holds 2 characters. `data_avail` is 1 whenever at least one character is stored. A read strobe while `data_avail`=1 loads the oldest character into `rd_data`/`rd_ferr` at the next clock edge and removes it from the queue.
- R7: A character that completes while the queue is full, with no read in the same cycle, is discarded. `overrun` then reads 1 until the next read that removes a character.
- R8: A read strobe while `data_avail`=0 leaves `rd_data`, `rd_ferr` and `overrun` unchanged.
- R9: One clock edge after `rx_enable` falls, the frame in progress is abandoned, the queue is empty and `overrun` is 0. `pin_owned` follows `rx_enable` with one clock of delay.
- R10: After enable, a start is only accepted once the line has been seen high at one tick. A line that is held low across enable produces no character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial input, idle high, asynchronous |
| rx_enable | input | 1 | Receiver enable; low aborts and flushes |
| fast_mode | input | 1 | 1: 8 ticks per bit, 0: 16 ticks per bit |
| os_tick | input | 1 | One-clock pulse at the oversampling rate |
| rd_strobe | input | 1 | Pops the oldest character into the output |
| rd_data | output | 8 | Last character read |
| rd_ferr | output | 1 | Stop-bit error flag of the last character read |
| data_avail | output | 1 | Queue holds at least one character |
| overrun | output | 1 | Sticky: a character was dropped on a full queue |
| pin_owned | output | 1 | Receiver holds the pin function |

## Verification
The line runs through a two-stage synchronizer. A change that the bench drives just after a tick is therefore seen at the following tick. Bench sample k of a bit is the k-th tick after that bit's level is applied. A character enters the queue two clocks after the tick that carries the stop bit's last vote. The bench checks `data_avail` only after it has finished driving the whole stop bit, which is several ticks later. A read strobe is applied for the length of one clock. `rd_data` is sampled at the following falling edge, which comes after the single register update. The effects of disabling are sampled at the first falling edge after the rising edge that registered the low enable.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } rx_state_e;
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign d_out = sh_q[STAGES-1];
endmodule

// File: rtl/rx_frame_engine.sv
module rx_frame_engine
    import uart_rx_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int OSR_NORM  = 16,
    parameter int OSR_FAST  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 fast_mode,
    input  logic                 os_tick,
    input  logic                 line,
    output logic                 push,
    output logic [DATA_BITS-1:0] push_data,
    output logic                 push_ferr
);
    localparam int CNT_W = $clog2(OSR_NORM + 1);
    localparam int BIT_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_BITS - 1);

    typedef struct packed {
        rx_state_e            state;
        logic [CNT_W-1:0]     cnt;
        logic [BIT_W-1:0]     bitidx;
        logic [DATA_BITS-1:0] shreg;
        logic                 v0;
        logic                 v1;
        logic                 prev;
        logic                 push;
        logic                 ferr;
    } eng_t;

    eng_t q, d;
    logic [CNT_W-1:0] osr, mid, idx;
    logic             maj;

    always_comb begin
        d      = q;
        d.push = 1'b0;
        osr    = fast_mode ? CNT_W'(OSR_FAST) : CNT_W'(OSR_NORM);
        mid    = osr >> 1;
        idx    = q.cnt + CNT_W'(1);
        maj    = (q.v0 & q.v1) | (q.v0 & line) | (q.v1 & line);
        if (!enable) begin
            d.state  = ST_HUNT;
            d.cnt    = '0;
            d.bitidx = '0;
            d.prev   = 1'b0;
        end else if (os_tick) begin
            d.prev = line;
            if (q.state == ST_HUNT) begin
                if (q.prev && !line) begin
                    d.state = ST_START;
                    d.cnt   = CNT_W'(1);
                end
            end else begin
                d.cnt = idx;
                if (idx == mid)               d.v0 = line;
                if (idx == mid + CNT_W'(1))   d.v1 = line;
                if (idx == mid + CNT_W'(2)) begin
                    unique case (q.state)
                        ST_START: if (maj) begin
                            d.state = ST_HUNT;
                            d.cnt   = '0;
                        end
                        ST_DATA:  d.shreg = {maj, q.shreg[DATA_BITS-1:1]};
                        ST_STOP: begin
                            d.push  = 1'b1;
                            d.ferr  = ~maj;
                            d.state = ST_HUNT;
                            d.cnt   = '0;
                        end
                        default: ;
                    endcase
                end
                if (idx >= osr && d.state != ST_HUNT) begin
                    d.cnt = '0;
                    unique case (q.state)
                        ST_START: begin
                            d.state  = ST_DATA;
                            d.bitidx = '0;
                        end
                        ST_DATA: begin
                            if (q.bitidx == LAST_BIT) d.state = ST_STOP;
                            else d.bitidx = q.bitidx + BIT_W'(1);
                        end
                        default: d.state = ST_HUNT;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state  <= ST_HUNT;
            q.cnt    <= '0;
            q.bitidx <= '0;
            q.shreg  <= '0;
            q.v0     <= 1'b0;
            q.v1     <= 1'b0;
            q.prev   <= 1'b0;
            q.push   <= 1'b0;
            q.ferr   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign push      = q.push;
    assign push_data = q.shreg;
    assign push_ferr = q.ferr;

    // R9: a low enable abandons the frame at the next edge
    p_abort_on_disable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (q.state == ST_HUNT));
    // R5: a character is only produced out of the stop-bit phase
    p_push_from_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        q.push |-> $past(q.state == ST_STOP));
    // R1: the sample index never runs past the longest bit
    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_W'(OSR_NORM));
    // R10: a start is never taken without a high sample first
    p_start_needs_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_HUNT && enable && os_tick && !q.prev) |=> (q.state == ST_HUNT));
endmodule

// File: rtl/rx_char_fifo.sv
module rx_char_fifo #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_word,
    input  logic             pop_req,
    output logic [WIDTH-1:0] out_word,
    output logic             avail,
    output logic             overrun
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [PTR_W-1:0]            wr_ptr;
        logic [PTR_W-1:0]            rd_ptr;
        logic [CNT_W-1:0]            count;
        logic [WIDTH-1:0]            out;
        logic                        ovr;
    } fifo_t;

    fifo_t q, d;
    logic pop, full, do_push;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1)) return '0;
        return p + PTR_W'(1);
    endfunction

    always_comb begin
        d       = q;
        full    = (q.count == CNT_W'(DEPTH));
        pop     = pop_req && (q.count != '0);
        do_push = push && (!full || pop);
        if (flush) begin
            d.wr_ptr = '0;
            d.rd_ptr = '0;
            d.count  = '0;
            d.ovr    = 1'b0;
        end else begin
            if (pop) begin
                d.out    = q.mem[q.rd_ptr];
                d.rd_ptr = ptr_inc(q.rd_ptr);
            end
            if (do_push) begin
                d.mem[q.wr_ptr] = push_word;
                d.wr_ptr        = ptr_inc(q.wr_ptr);
            end
            if (do_push && !pop)      d.count = q.count + CNT_W'(1);
            else if (pop && !do_push) d.count = q.count - CNT_W'(1);
            if (push && full && !pop) d.ovr = 1'b1;
            else if (pop)             d.ovr = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.mem    <= '0;
            q.wr_ptr <= '0;
            q.rd_ptr <= '0;
            q.count  <= '0;
            q.out    <= '0;
            q.ovr    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign out_word = q.out;
    assign avail    = (q.count != '0);
    assign overrun  = q.ovr;

    // R6: occupancy never exceeds the queue depth
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q.count <= CNT_W'(DEPTH));
    // R9: a flush leaves the queue empty and the loss flag clear
    p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!avail && !overrun));
    // R7: a push on a full queue without a pop raises the loss flag
    p_overrun_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !avail ? 1'b0 : (push && q.count == CNT_W'(DEPTH) && !pop_req && !flush)) |=> overrun);
    // R8: a read of an empty queue leaves the output alone
    p_empty_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !avail && !flush) |=> $stable(out_word));
endmodule

// File: rtl/uart_rx_os.sv
module uart_rx_os #(
    parameter int DATA_BITS   = 8,
    parameter int OSR_NORM    = 16,
    parameter int OSR_FAST    = 8,
    parameter int FIFO_DEPTH  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_line,
    input  logic                 rx_enable,
    input  logic                 fast_mode,
    input  logic                 os_tick,
    input  logic                 rd_strobe,
    output logic [DATA_BITS-1:0] rd_data,
    output logic                 rd_ferr,
    output logic                 data_avail,
    output logic                 overrun,
    output logic                 pin_owned
);
    localparam int WORD_W = DATA_BITS + 1;

    logic                 line_s;
    logic                 push;
    logic [DATA_BITS-1:0] push_data;
    logic                 push_ferr;
    logic [WORD_W-1:0]    out_word;
    logic                 own_d, own_q;

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (rx_line),
        .d_out (line_s)
    );

    rx_frame_engine #(
        .DATA_BITS (DATA_BITS),
        .OSR_NORM  (OSR_NORM),
        .OSR_FAST  (OSR_FAST)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (rx_enable),
        .fast_mode (fast_mode),
        .os_tick   (os_tick),
        .line      (line_s),
        .push      (push),
        .push_data (push_data),
        .push_ferr (push_ferr)
    );

    rx_char_fifo #(
        .WIDTH (WORD_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (!rx_enable),
        .push      (push),
        .push_word ({push_ferr, push_data}),
        .pop_req   (rd_strobe),
        .out_word  (out_word),
        .avail     (data_avail),
        .overrun   (overrun)
    );

    always_comb own_d = rx_enable;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) own_q <= 1'b0;
        else        own_q <= own_d;
    end

    assign pin_owned = own_q;
    assign rd_data   = out_word[DATA_BITS-1:0];
    assign rd_ferr   = out_word[DATA_BITS];

    // R9: pin ownership follows the enable one edge later
    p_pin_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_enable |=> !pin_owned);
    p_pin_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_enable |=> pin_owned);
endmodule

// File: tb/tb_uart_rx_os.sv
`timescale 1ns/1ps
module tb_uart_rx_os;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic       rx_enable = 1'b0;
    logic       fast_mode = 1'b0;
    logic       os_tick = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [7:0] rd_data;
    logic       rd_ferr, data_avail, overrun, pin_owned;
    logic [1:0] tcnt = '0;
    int tests = 0;
    int fails = 0;
    logic [8:0] model[$];
    logic       exp_ovr;

    uart_rx_os dut (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .rx_enable(rx_enable),
        .fast_mode(fast_mode), .os_tick(os_tick), .rd_strobe(rd_strobe),
        .rd_data(rd_data), .rd_ferr(rd_ferr), .data_avail(data_avail),
        .overrun(overrun), .pin_owned(pin_owned)
    );

    always #5 clk = ~clk;

    always @(negedge clk) begin
        tcnt    <= tcnt + 2'd1;
        os_tick <= (tcnt == 2'd3);
    end

    function automatic logic [8:0] exp_word(input logic [7:0] b, input logic stop_ok);
        return {~stop_ok, b};
    endfunction

    function automatic int ticks_per_bit(input logic fast);
        return fast ? 8 : 16;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_tick();
        do @(posedge clk); while (!os_tick);
        #1;
    endtask

    task automatic idle(input int n);
        rx_line = 1'b1;
        repeat (n) wait_tick();
    endtask

    // flip_bit: index 0..9 of the frame bit whose centre sample is inverted, -1 none
    task automatic send_frame(input logic [7:0] b, input logic stop_ok, input int flip_bit);
        int osr;
        logic [9:0] bits;
        osr  = ticks_per_bit(fast_mode);
        bits = {stop_ok, b, 1'b0};
        wait_tick();
        for (int i = 0; i < 10; i++) begin
            if (i == flip_bit) begin
                rx_line = bits[i];
                repeat (osr / 2) wait_tick();
                rx_line = ~bits[i];
                wait_tick();
                rx_line = bits[i];
                repeat (osr - osr / 2 - 1) wait_tick();
            end else begin
                rx_line = bits[i];
                repeat (osr) wait_tick();
            end
        end
        rx_line = 1'b1;
        if (model.size() < 2) model.push_back(exp_word(b, stop_ok));
        else exp_ovr = 1'b1;
        repeat (2) wait_tick();
    endtask

    task automatic read_char();
        @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    task automatic read_and_check(input string req);
        logic [8:0] e;
        check({req, " avail"}, 32'(data_avail), 32'd1);
        e = model.pop_front();
        read_char();
        check({req, " data"}, 32'({rd_ferr, rd_data}), 32'(e));
        exp_ovr = 1'b0;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #1_500_000;
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [7:0] last;
        void'($urandom(32'd20240611));
        exp_ovr = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        check("R6 reset avail", 32'(data_avail), 32'd0);
        check("R7 reset overrun", 32'(overrun), 32'd0);
        check("R9 reset pin_owned", 32'(pin_owned), 32'd0);
        rx_enable = 1'b1;
        @(negedge clk);
        check("R9 pin_owned after enable", 32'(pin_owned), 32'd1);
        idle(4);

        // R1 R2 R3 R5 R6: random characters, random mode, random centre flips
        for (int k = 0; k < 14; k++) begin
            logic [7:0] b;
            int fl;
            b  = 8'($urandom);
            fast_mode = 1'($urandom);
            fl = ($urandom % 3 == 0) ? int'($urandom % 10) : -1;
            idle(2);
            send_frame(b, 1'b1, fl);
            read_and_check(fast_mode ? "R2 R3 fast" : "R1 R3 normal");
            check("R6 empty after read", 32'(data_avail), 32'd0);
        end

        // R5: low stop bit in both modes
        fast_mode = 1'b0;
        idle(4);
        send_frame(8'hA5, 1'b0, -1);
        read_and_check("R5 ferr normal");
        fast_mode = 1'b1;
        idle(20);
        send_frame(8'h3C, 1'b0, -1);
        read_and_check("R5 ferr fast");
        idle(20);

        // R4: start glitch
        fast_mode = 1'b0;
        wait_tick();
        rx_line = 1'b0;
        repeat (3) wait_tick();
        idle(60);
        check("R4 glitch stores nothing", 32'(data_avail), 32'd0);
        fast_mode = 1'b1;
        wait_tick();
        rx_line = 1'b0;
        repeat (2) wait_tick();
        idle(40);
        check("R4 glitch fast stores nothing", 32'(data_avail), 32'd0);
        fast_mode = 1'b0;

        // R7: third character on a full queue
        send_frame(8'h11, 1'b1, -1);
        idle(2);
        send_frame(8'h22, 1'b1, -1);
        check("R7 overrun clear before loss", 32'(overrun), 32'd0);
        idle(2);
        send_frame(8'h33, 1'b1, -1);
        check("R7 overrun set", 32'(overrun), 32'(exp_ovr));
        read_and_check("R7 first kept");
        check("R7 overrun cleared by read", 32'(overrun), 32'd0);
        read_and_check("R7 second kept");
        check("R7 third dropped", 32'(data_avail), 32'd0);
        last = rd_data;

        // R8: empty read
        read_char();
        check("R8 rd_data unchanged", 32'(rd_data), 32'(last));
        check("R8 avail stays low", 32'(data_avail), 32'd0);

        // R9: flush with queue full
        idle(2);
        send_frame(8'h5A, 1'b1, -1);
        idle(2);
        send_frame(8'hC3, 1'b1, -1);
        check("R9 queue loaded", 32'(data_avail), 32'd1);
        @(negedge clk);
        rx_enable = 1'b0;
        @(negedge clk);
        check("R9 flushed", 32'(data_avail), 32'd0);
        check("R9 pin released", 32'(pin_owned), 32'd0);
        model.delete();
        rx_enable = 1'b1;
        idle(4);

        // R9: abort mid-frame
        wait_tick();
        rx_line = 1'b0;
        repeat (16) wait_tick();
        rx_line = 1'b1;
        repeat (16) wait_tick();
        rx_line = 1'b0;
        repeat (10) wait_tick();
        @(negedge clk);
        rx_enable = 1'b0;
        rx_line = 1'b1;
        @(negedge clk);
        rx_enable = 1'b1;
        idle(200);
        check("R9 aborted frame not stored", 32'(data_avail), 32'd0);

        // R10: line held low across enable
        @(negedge clk);
        rx_enable = 1'b0;
        rx_line = 1'b0;
        repeat (8) @(negedge clk);
        rx_enable = 1'b1;
        repeat (40) wait_tick();
        check("R10 low line gives no start", 32'(data_avail), 32'd0);
        idle(40);
        check("R10 still empty after idle", 32'(data_avail), 32'd0);
        send_frame(8'h96, 1'b1, -1);
        read_and_check("R10 next frame clean");
        check("R10 only one char", 32'(data_avail), 32'd0);

        summary();
    end
endmodule